// File: doc/BRIEF.md
# DMA Channel Request Arbiter and Linker

This block decides which of sixteen DMA channels the transfer engine serves next. A channel can ask for service in three ways. Software can set a start bit. The channel's own peripheral can hold up a request line. Another channel can link to it when that channel finishes a loop. All three request kinds are merged per channel. The arbiter then picks one channel under a mode input. In fixed mode the highest channel number wins. In round-robin mode the search begins just after the last channel granted.

A pick is announced as a one-cycle grant pulse that carries the channel number. The block then stays busy until the engine reports that the minor loop is done. Each grant pays for exactly one minor loop, whatever the request source was. When the done pulse arrives, the finished channel can raise a request on a programmed target channel. Which target is used depends on whether the loop that finished was a minor loop only or also the final major iteration. The block also ORs the per-channel error flags, masked by their enables, into one error interrupt.

Top module: `dma_req_arbiter`

## Requirements
- R1: With `rr_mode`=0 (fixed), the pending channel with the highest index is granted; channel 15 beats all others and channel 0 loses to all others.
- R2: With `rr_mode`=1 (round-robin), the first pending channel found is granted. The search starts at the channel after the last granted one and wraps from 15 to 0. After reset the search starts at channel 0.
- R3: `grant_valid` is high for exactly one cycle per grant, and `busy` rises with it. No further grant is issued while `busy` is high, even if requests are pending.
- R4: A `minor_done` pulse while `busy` clears `busy` at that edge. The next grant can appear no sooner than the following clock edge, and appears at that edge if a request is pending.
- R5: A pulse on `sw_start_set[k]` holds a request for channel k until k is granted. The grant clears it, so the pulse yields exactly one grant.
- R6: `hw_req[k]` is a level request with no memory. If it drops before channel k could be granted, no grant for k follows.
- R7: Consider a `minor_done` with `major_done`=0 from active channel a, where `minor_link_en[a]`=1. It raises a pending request on the channel given by `minor_link_tgt[a*4 +: 4]`.
- R8: Consider a `minor_done` with `major_done`=1 from active channel a. If `major_link_en[a]`=1, it raises a request on the channel given by `major_link_tgt[a*4 +: 4]`. The minor-loop link of a is not raised on that iteration.
- R9: A pending link request is cleared when its channel is granted, so one link event yields one grant.
- R10: `err_irq` equals the OR over all channels of `err_en & err_flag`, registered one cycle.
- R11: After reset, `grant_valid`, `busy` and `err_irq` are 0.
- R12: A `minor_done` pulse while not `busy` has no effect. No grant follows and no link is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rr_mode | input | 1 | 0 selects fixed priority, 1 selects round-robin |
| sw_start_set | input | 16 | One-cycle pulses that set per-channel software start bits |
| hw_req | input | 16 | Per-channel peripheral request levels |
| minor_link_en | input | 16 | Per-channel enable for linking at minor-loop end |
| minor_link_tgt | input | 64 | Per-channel minor-loop link target, 4 bits each |
| major_link_en | input | 16 | Per-channel enable for linking at major-loop end |
| major_link_tgt | input | 64 | Per-channel major-loop link target, 4 bits each |
| minor_done | input | 1 | Engine finished the minor loop of the granted channel |
| major_done | input | 1 | Qualifies `minor_done`: this was the final major iteration |
| err_en | input | 16 | Per-channel error interrupt enables |
| err_flag | input | 16 | Per-channel error conditions |
| grant_valid | output | 1 | One-cycle grant pulse |
| grant_ch | output | 4 | Granted channel, valid with `grant_valid` |
| busy | output | 1 | A granted channel is being served |
| err_irq | output | 1 | Combined error interrupt |

## Verification
A wrong priority scan or a stale last-grant pointer shows at the next grant as a wrong `grant_ch`. That happens one edge after the arbitration cycle. A software start or link bit that fails to clear shows as an extra grant right after the following `minor_done`. One that was never set shows as a missing grant within two edges of the done pulse. A stuck `busy` blocks every later grant, and the bench detects it within a few cycles.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    typedef enum logic {
        ARB_FIXED = 1'b0,
        ARB_RR    = 1'b1
    } arb_mode_e;
endpackage

// File: rtl/dma_arb_pick.sv
// Combinational winner selection: fixed (highest index) or rotating.
module dma_arb_pick #(
    parameter int NUM_CH = 16,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req,
    input  logic              rotate,
    input  logic [CH_W-1:0]   last,
    output logic              found,
    output logic [CH_W-1:0]   win
);
    always_comb begin
        found = 1'b0;
        win   = '0;
        if (rotate) begin
            for (int i = 0; i < NUM_CH; i++) begin
                automatic int idx = (int'(last) + 1 + i) % NUM_CH;
                if (!found && req[idx]) begin
                    found = 1'b1;
                    win   = CH_W'(idx);
                end
            end
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (req[i]) begin
                    found = 1'b1;
                    win   = CH_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/dma_link_route.sv
// Decodes the link request raised when the active channel finishes a loop.
module dma_link_route #(
    parameter int NUM_CH = 16,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic                   fire,
    input  logic                   final_iter,
    input  logic [CH_W-1:0]        act_ch,
    input  logic [NUM_CH-1:0]      minor_en,
    input  logic [NUM_CH*CH_W-1:0] minor_tgt,
    input  logic [NUM_CH-1:0]      major_en,
    input  logic [NUM_CH*CH_W-1:0] major_tgt,
    output logic [NUM_CH-1:0]      set_mask
);
    logic [CH_W-1:0] minor_sel;
    logic [CH_W-1:0] major_sel;

    always_comb begin
        minor_sel = minor_tgt[int'(act_ch)*CH_W +: CH_W];
        major_sel = major_tgt[int'(act_ch)*CH_W +: CH_W];
        set_mask  = '0;
        if (fire) begin
            if (final_iter) begin
                if (major_en[act_ch]) set_mask[major_sel] = 1'b1;
            end else begin
                if (minor_en[act_ch]) set_mask[minor_sel] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rr_mode,
    input  logic [NUM_CH-1:0]      sw_start_set,
    input  logic [NUM_CH-1:0]      hw_req,
    input  logic [NUM_CH-1:0]      minor_link_en,
    input  logic [NUM_CH*CH_W-1:0] minor_link_tgt,
    input  logic [NUM_CH-1:0]      major_link_en,
    input  logic [NUM_CH*CH_W-1:0] major_link_tgt,
    input  logic                   minor_done,
    input  logic                   major_done,
    input  logic [NUM_CH-1:0]      err_en,
    input  logic [NUM_CH-1:0]      err_flag,
    output logic                   grant_valid,
    output logic [CH_W-1:0]        grant_ch,
    output logic                   busy,
    output logic                   err_irq
);
    typedef struct packed {
        logic              busy;
        logic              gnt;
        logic [CH_W-1:0]   gch;
        logic [CH_W-1:0]   last;
        logic [NUM_CH-1:0] sw;
        logic [NUM_CH-1:0] link;
        logic              err;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [NUM_CH-1:0] pending;
    logic              pick_found;
    logic [CH_W-1:0]   pick_win;
    logic [NUM_CH-1:0] link_set;
    logic [NUM_CH-1:0] gnt_mask;
    logic              loop_end;

    assign pending  = st_q.sw | st_q.link | hw_req;
    assign loop_end = st_q.busy & minor_done;

    dma_arb_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
        .req    (pending),
        .rotate (rr_mode == ARB_RR),
        .last   (st_q.last),
        .found  (pick_found),
        .win    (pick_win)
    );

    dma_link_route #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_link (
        .fire       (loop_end),
        .final_iter (major_done),
        .act_ch     (st_q.last),
        .minor_en   (minor_link_en),
        .minor_tgt  (minor_link_tgt),
        .major_en   (major_link_en),
        .major_tgt  (major_link_tgt),
        .set_mask   (link_set)
    );

    always_comb begin
        st_d     = st_q;
        st_d.gnt = 1'b0;
        gnt_mask = '0;
        if (st_q.busy) begin
            if (minor_done) st_d.busy = 1'b0;
        end else if (pick_found) begin
            st_d.busy          = 1'b1;
            st_d.gnt           = 1'b1;
            st_d.gch           = pick_win;
            st_d.last          = pick_win;
            gnt_mask[pick_win] = 1'b1;
        end
        st_d.sw   = (st_q.sw & ~gnt_mask) | sw_start_set;
        st_d.link = (st_q.link & ~gnt_mask) | link_set;
        st_d.err  = |(err_en & err_flag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.last <= CH_W'(NUM_CH - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_valid = st_q.gnt;
    assign grant_ch    = st_q.gch;
    assign busy        = st_q.busy;
    assign err_irq     = st_q.err;
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
    parameter int NUM_CH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              grant_valid,
    input logic              busy,
    input logic              minor_done,
    input logic              err_irq,
    input logic [NUM_CH-1:0] err_en,
    input logic [NUM_CH-1:0] err_flag
);
    AST_GRANT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> !grant_valid); // R3

    AST_GRANT_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> busy); // R3

    AST_NO_GRANT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !minor_done) |=> !grant_valid); // R3

    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && minor_done) |=> (!busy && !grant_valid)); // R4

    AST_ERR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (err_irq == $past(|(err_en & err_flag)))); // R10
endmodule

bind dma_req_arbiter dma_arb_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_valid (grant_valid),
    .busy        (busy),
    .minor_done  (minor_done),
    .err_irq     (err_irq),
    .err_en      (err_en),
    .err_flag    (err_flag)
);

// File: tb/test_dma_req_arbiter.sv
module test_dma_req_arbiter;
    localparam int N = 16;
    localparam int W = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rr_mode = 1'b0;
    logic [N-1:0]  sw_start_set = '0;
    logic [N-1:0]  hw_req = '0;
    logic [N-1:0]  minor_link_en = '0;
    logic [N*W-1:0] minor_link_tgt = '0;
    logic [N-1:0]  major_link_en = '0;
    logic [N*W-1:0] major_link_tgt = '0;
    logic          minor_done = 1'b0;
    logic          major_done = 1'b0;
    logic [N-1:0]  err_en = '0;
    logic [N-1:0]  err_flag = '0;
    logic          grant_valid;
    logic [W-1:0]  grant_ch;
    logic          busy;
    logic          err_irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    dma_req_arbiter i_dma_req_arbiter (
        .clk, .rst_n, .rr_mode, .sw_start_set, .hw_req,
        .minor_link_en, .minor_link_tgt, .major_link_en, .major_link_tgt,
        .minor_done, .major_done, .err_en, .err_flag,
        .grant_valid, .grant_ch, .busy, .err_irq
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 20000);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // fields: {rr_mode, hw_req, expected channel}
    localparam logic [20:0] VEC [10] = '{
        {1'b0, 16'h0001, 4'd0},
        {1'b0, 16'h8001, 4'd15},
        {1'b0, 16'h00F0, 4'd7},
        {1'b0, 16'h0A00, 4'd11},
        {1'b1, 16'h0901, 4'd0},
        {1'b1, 16'h0901, 4'd8},
        {1'b1, 16'h0901, 4'd11},
        {1'b1, 16'h0901, 4'd0},
        {1'b1, 16'h8000, 4'd15},
        {1'b1, 16'h0003, 4'd0}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // wait up to 8 cycles for a grant, check its channel
    task automatic wait_grant(input int exp, input string req);
        int n = 0;
        while (!grant_valid && n < 8) begin tick(); n++; end
        if (!grant_valid) chk(1'b0, req, -1, exp);
        else chk(grant_ch == W'(exp), req, int'(grant_ch), exp);
    endtask

    task automatic end_loop(input logic fin);
        minor_done = 1'b1;
        major_done = fin;
        tick();
        minor_done = 1'b0;
        major_done = 1'b0;
    endtask

    task automatic no_grant(input int cycles, input string req);
        logic seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            tick();
            if (grant_valid) seen = 1'b1;
        end
        chk(!seen, req, int'(seen), 0);
    endtask

    initial begin
        tick(); tick();
        // R11 reset state
        chk(!grant_valid && !busy && !err_irq, "R11", int'({grant_valid, busy, err_irq}), 0);
        rst_n = 1'b1;
        tick();

        // table: R1 fixed, R2 round-robin
        foreach (VEC[v]) begin
            rr_mode = VEC[v][20];
            hw_req  = VEC[v][19:4];
            wait_grant(int'(VEC[v][3:0]), VEC[v][20] ? "R2" : "R1");
            hw_req = '0;
            end_loop(1'b0);
        end
        tick();
        rr_mode = 1'b0;

        // R3 single pulse and blocking while busy; R4 release timing
        hw_req = 16'h0004;
        wait_grant(2, "R1");
        hw_req = 16'h0100;
        tick();
        chk(!grant_valid && busy, "R3", int'({grant_valid, busy}), 1);
        no_grant(4, "R3");
        end_loop(1'b0);
        chk(!busy && !grant_valid, "R4", int'({grant_valid, busy}), 0);
        tick();
        chk(grant_valid && grant_ch == 4'd8, "R4", int'(grant_ch), 8);
        hw_req = '0;
        end_loop(1'b0);

        // R5 software start: held while busy, cleared on grant
        sw_start_set = 16'h0020;
        tick();
        sw_start_set = '0;
        wait_grant(5, "R5");
        sw_start_set = 16'h0200;
        tick();
        sw_start_set = '0;
        end_loop(1'b0);
        wait_grant(9, "R5");
        end_loop(1'b0);
        no_grant(5, "R5");

        // R6 hardware level dropped before service
        hw_req = 16'h0001;
        wait_grant(0, "R1");
        hw_req = 16'h0010;
        tick(); tick();
        hw_req = '0;
        end_loop(1'b0);
        no_grant(5, "R6");

        // R7 minor link, R9 cleared on grant
        minor_link_en = 16'h0004;
        minor_link_tgt[2*W +: W] = 4'd12;
        major_link_en = 16'h0004;
        major_link_tgt[2*W +: W] = 4'd6;
        sw_start_set = 16'h0004;
        tick();
        sw_start_set = '0;
        wait_grant(2, "R5");
        end_loop(1'b0);
        wait_grant(12, "R7");
        end_loop(1'b0);
        no_grant(5, "R9");

        // R8 major link only on final iteration
        sw_start_set = 16'h0004;
        tick();
        sw_start_set = '0;
        wait_grant(2, "R5");
        end_loop(1'b1);
        wait_grant(6, "R8");
        end_loop(1'b0);
        no_grant(5, "R8");

        // R12 done while idle: last granted is 6, give it a minor link
        minor_link_en = 16'h0040;
        minor_link_tgt[6*W +: W] = 4'd3;
        end_loop(1'b0);
        chk(!busy, "R12", int'(busy), 0);
        no_grant(5, "R12");

        // R10 error combine
        err_en = 16'h0010;
        err_flag = 16'h0020;
        tick(); tick();
        chk(!err_irq, "R10", int'(err_irq), 0);
        err_flag = 16'h0030;
        tick();
        chk(err_irq, "R10", int'(err_irq), 1);
        err_en = '0;
        tick();
        chk(!err_irq, "R10", int'(err_irq), 0);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule